// File: doc/BRIEF.md
# Context-Adaptive Bitplane Decoder

This block is the modelling stage of an entropy decompressor. It asks an external run-length generator for one raw bit at a time, naming the code order that the generator should use. It turns each raw bit into a decoded bit and packs the decoded bits into bytes for a consumer. A header byte is loaded with a start pulse. It chooses how the decoder steps through eight bitplanes, and which bits of each plane's history make up the context.

There are 32 contexts. Each one holds an adaptive probability state from a 33-entry evolution table, plus a most-probable-symbol (MPS) value. The state of a context picks the code order requested for the next bit. A context changes only when the generator reports that a run has ended. In the three interleaved modes, sixteen bits yield a pair of bytes. The second byte of the pair is held and returned on the next request without any generator traffic.

The control path is a three-state machine. ST_IDLE waits for the consumer. It goes to ST_EMIT when a held byte exists, or to ST_FETCH otherwise. ST_FETCH requests bits and moves to ST_EMIT when the last bit of a group is accepted. ST_EMIT presents the byte and returns to ST_IDLE when the byte is taken. A start pulse forces ST_IDLE from any state.

Top module: `ctxplane_decoder`

## Requirements
- R1: `header[7:6]` selects the plane mode: 0 pair, 1 rotate, 2 swap, 3 serial. `header[5:4]` selects the context template (0 to 3). Both are captured on `start`.
- R2: `start` puts every context into state 0 with MPS 0. It also clears all plane histories, the bit counter, the bit position and any held byte. A stream decoded after a restart therefore matches a fresh one.
- R3: While a bit is requested, `gen_order` equals the code-order column of the evolution table for the current context's state. State 0 uses order 0.
- R4: A context's state moves only on an accepted bit with `gen_eor` high. It goes to the MPS successor when `gen_bit` is 0, and to the LPS successor when `gen_bit` is 1. An LPS at end of run in state 0 or 1 inverts the context's MPS.
- R5: The decoded bit is `gen_bit` XOR the context's MPS value from before that bit's update.
- R6: The plane starts at 1, 7 or 3 in modes 0, 1 and 2. Modes 0 to 2 invert plane bit 0 on every bit. Whenever the 8-bit counter's low 7 bits are zero before the bit, mode 1 then adds 2 modulo 8 and mode 2 inverts plane bit 1. Mode 3 takes the counter's low 3 bits as the plane.
- R7: The context is {plane bit 0, t}, where h is the 16-bit history of the plane in use. The 4-bit t is {h[8:6],h[0]} for template 0, {h[8:7],0,h[0]} for template 1, {0,h[7:6],h[0]} for template 2 and {h[8:7],h[1:0]} for template 3. Each decoded bit shifts into its plane's history at bit 0.
- R8: In modes 0 to 2, sixteen decoded bits alternate between a first and a second byte, each filled MSB first. The first byte is returned. The second byte is returned by the next request without any generator request.
- R9: In mode 3, eight decoded bits fill one byte LSB first.
- R10: `dout_valid` holds with stable `dout_data` until `dout_ready`. `gen_req` holds with a stable `gen_order` until `gen_ack`. The two are never high together, and neither rises without a consumer request.
- R11: After reset, `dout_valid` and `gen_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load header and reinitialise all model state |
| header | input | 8 | Mode and template selection byte |
| dout_ready | input | 1 | Consumer requests/accepts a byte |
| dout_valid | output | 1 | Decoded byte available |
| dout_data | output | 8 | Decoded byte |
| gen_req | output | 1 | Request one raw bit from the run generator |
| gen_order | output | 3 | Code order for the requested bit |
| gen_ack | input | 1 | Generator supplies a bit this cycle |
| gen_bit | input | 1 | Raw bit (1 = less probable symbol) |
| gen_eor | input | 1 | This bit ends a run |

## Verification
A wrong state, MPS, plane or history value first shows up on `gen_order`. It can also show up on the decoded bits, within the same few requests that touch the faulty context. Every requested order is therefore compared against an independent model, bit by bit. Later errors follow from any early slip, because the history feeds the next context, so byte comparisons catch a fault within one byte group. Rotation faults in modes 1 and 2 only appear after the 128-bit boundary, so those streams run past it.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

    typedef enum logic [1:0] {
        PM_PAIR   = 2'd0,
        PM_ROT    = 2'd1,
        PM_SWAP   = 2'd2,
        PM_SERIAL = 2'd3
    } plane_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } fsm_e;

    localparam int PL_W    = 3;
    localparam int STATE_W = 6;
    localparam int CTX_W   = 5;

    typedef struct packed {
        logic [2:0]         order;
        logic [STATE_W-1:0] on_mps;
        logic [STATE_W-1:0] on_lps;
    } evo_t;

    function automatic evo_t evo_lookup(input logic [STATE_W-1:0] s);
        case (s)
            6'd1:  return '{3'd0, 6'd2,  6'd1};
            6'd2:  return '{3'd0, 6'd3,  6'd1};
            6'd3:  return '{3'd0, 6'd4,  6'd2};
            6'd4:  return '{3'd0, 6'd5,  6'd3};
            6'd5:  return '{3'd1, 6'd6,  6'd4};
            6'd6:  return '{3'd1, 6'd7,  6'd5};
            6'd7:  return '{3'd1, 6'd8,  6'd6};
            6'd8:  return '{3'd1, 6'd9,  6'd7};
            6'd9:  return '{3'd2, 6'd10, 6'd8};
            6'd10: return '{3'd2, 6'd11, 6'd9};
            6'd11: return '{3'd2, 6'd12, 6'd10};
            6'd12: return '{3'd2, 6'd13, 6'd11};
            6'd13: return '{3'd3, 6'd14, 6'd12};
            6'd14: return '{3'd3, 6'd15, 6'd13};
            6'd15: return '{3'd3, 6'd16, 6'd14};
            6'd16: return '{3'd3, 6'd17, 6'd15};
            6'd17: return '{3'd4, 6'd18, 6'd16};
            6'd18: return '{3'd4, 6'd19, 6'd17};
            6'd19: return '{3'd5, 6'd20, 6'd18};
            6'd20: return '{3'd5, 6'd21, 6'd19};
            6'd21: return '{3'd6, 6'd22, 6'd20};
            6'd22: return '{3'd6, 6'd23, 6'd21};
            6'd23: return '{3'd7, 6'd24, 6'd22};
            6'd24: return '{3'd7, 6'd24, 6'd23};
            6'd25: return '{3'd0, 6'd26, 6'd1};
            6'd26: return '{3'd1, 6'd27, 6'd2};
            6'd27: return '{3'd2, 6'd28, 6'd4};
            6'd28: return '{3'd3, 6'd29, 6'd8};
            6'd29: return '{3'd4, 6'd30, 6'd12};
            6'd30: return '{3'd5, 6'd31, 6'd16};
            6'd31: return '{3'd6, 6'd32, 6'd18};
            6'd32: return '{3'd7, 6'd24, 6'd22};
            default: return '{3'd0, 6'd25, 6'd25};
        endcase
    endfunction

    function automatic logic [PL_W-1:0] first_plane(input plane_mode_e m);
        case (m)
            PM_PAIR: return 3'd1;
            PM_ROT:  return 3'd7;
            PM_SWAP: return 3'd3;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/cbd_ctx_store.sv
module cbd_ctx_store
    import cbd_pkg::*;
#(
    parameter int NUM_CTX = 32,
    localparam int IDX_W = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [IDX_W-1:0] idx,
    input  logic             upd,
    input  logic             raw_bit,
    input  logic             eor,
    output logic [2:0]       order,
    output logic             mps
);

    logic [STATE_W-1:0] st_q  [NUM_CTX];
    logic               mps_q [NUM_CTX];
    evo_t               cur;

    assign cur   = evo_lookup(st_q[idx]);
    assign order = cur.order;
    assign mps   = mps_q[idx];

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i]  <= '0;
                mps_q[i] <= 1'b0;
            end else if (clear) begin
                st_q[i]  <= '0;
                mps_q[i] <= 1'b0;
            end else if (upd && eor && (idx == IDX_W'(i))) begin
                st_q[i] <= raw_bit ? cur.on_lps : cur.on_mps;
                if (raw_bit && (st_q[i] <= STATE_W'(1)))
                    mps_q[i] <= ~mps_q[i];
            end
        end
    end

endmodule

// File: rtl/cbd_plane_seq.sv
module cbd_plane_seq
    import cbd_pkg::*;
#(
    parameter int HIST_W    = 16,
    parameter int CNT_W     = 8,
    parameter int EPOCH_LOG = 7,
    localparam int PLANES   = 1 << PL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  plane_mode_e      mode,
    input  logic [1:0]       tmpl,
    input  logic             step,
    input  logic             bit_in,
    output logic [CTX_W-1:0] ctx
);

    logic [PL_W-1:0]   plane_q, plane_n;
    logic [CNT_W-1:0]  cnt_q;
    logic [HIST_W-1:0] hist_q [PLANES];
    logic [HIST_W-1:0] h;
    logic [3:0]        low;
    logic              epoch;

    assign epoch = (cnt_q[EPOCH_LOG-1:0] == '0);

    always_comb begin
        unique case (mode)
            PM_PAIR:   plane_n = plane_q ^ 3'd1;
            PM_ROT:    plane_n = epoch ? ((plane_q ^ 3'd1) + 3'd2) : (plane_q ^ 3'd1);
            PM_SWAP:   plane_n = epoch ? (plane_q ^ 3'd3) : (plane_q ^ 3'd1);
            PM_SERIAL: plane_n = cnt_q[PL_W-1:0];
        endcase
    end

    assign h = hist_q[plane_n];

    always_comb begin
        unique case (tmpl)
            2'd0: low = {h[8:6], h[0]};
            2'd1: low = {h[8:7], 1'b0, h[0]};
            2'd2: low = {1'b0, h[7:6], h[0]};
            2'd3: low = {h[8:7], h[1:0]};
        endcase
    end

    assign ctx = {plane_n[0], low};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plane_q <= '0;
            cnt_q   <= '0;
            for (int p = 0; p < PLANES; p++) hist_q[p] <= '0;
        end else if (clear) begin
            plane_q <= first_plane(mode);
            cnt_q   <= '0;
            for (int p = 0; p < PLANES; p++) hist_q[p] <= '0;
        end else if (step) begin
            plane_q         <= plane_n;
            cnt_q           <= cnt_q + 1'b1;
            hist_q[plane_n] <= {h[HIST_W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/ctxplane_decoder.sv
module ctxplane_decoder
    import cbd_pkg::*;
#(
    parameter int HIST_W    = 16,
    parameter int CNT_W     = 8,
    parameter int EPOCH_LOG = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] header,
    input  logic       dout_ready,
    output logic       dout_valid,
    output logic [7:0] dout_data,
    output logic       gen_req,
    output logic [2:0] gen_order,
    input  logic       gen_ack,
    input  logic       gen_bit,
    input  logic       gen_eor
);

    localparam int NUM_CTX = 1 << CTX_W;
    localparam int POS_W   = 4;

    fsm_e              st_q, st_d;
    plane_mode_e       mode_q, mode_eff;
    logic [1:0]        tmpl_q;
    logic [POS_W-1:0]  pos_q;
    logic [7:0]        acc_a, acc_b, acc_a_n, acc_b_n, held_q, out_q;
    logic              held_v;
    logic [CTX_W-1:0]  ctx;
    logic              cur_mps, dec_bit, step, pair, last;

    assign mode_eff = start ? plane_mode_e'(header[7:6]) : mode_q;
    assign step     = (st_q == ST_FETCH) && gen_ack && !start;
    assign dec_bit  = gen_bit ^ cur_mps;
    assign pair     = (mode_q != PM_SERIAL);
    assign last     = pair ? (pos_q == 4'd15) : (pos_q == 4'd7);

    cbd_plane_seq #(.HIST_W(HIST_W), .CNT_W(CNT_W), .EPOCH_LOG(EPOCH_LOG)) u_seq (
        .clk(clk), .rst_n(rst_n), .clear(start), .mode(mode_eff), .tmpl(tmpl_q),
        .step(step), .bit_in(dec_bit), .ctx(ctx)
    );

    cbd_ctx_store #(.NUM_CTX(NUM_CTX)) u_ctx (
        .clk(clk), .rst_n(rst_n), .clear(start), .idx(ctx), .upd(step),
        .raw_bit(gen_bit), .eor(gen_eor), .order(gen_order), .mps(cur_mps)
    );

    always_comb begin
        acc_a_n = acc_a;
        acc_b_n = acc_b;
        if (pair) begin
            if (!pos_q[0]) acc_a_n[3'd7 - pos_q[3:1]] = dec_bit;
            else           acc_b_n[3'd7 - pos_q[3:1]] = dec_bit;
        end else begin
            acc_a_n[pos_q[2:0]] = dec_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (dout_ready) st_d = held_v ? ST_EMIT : ST_FETCH;
                ST_FETCH: if (gen_ack && last) st_d = ST_EMIT;
                ST_EMIT:  if (dout_ready) st_d = ST_IDLE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        gen_req    = (st_q == ST_FETCH);
        dout_valid = (st_q == ST_EMIT);
        dout_data  = out_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PM_PAIR;
            tmpl_q <= '0;
            pos_q  <= '0;
            acc_a  <= '0;
            acc_b  <= '0;
            held_q <= '0;
            held_v <= 1'b0;
            out_q  <= '0;
        end else if (start) begin
            mode_q <= plane_mode_e'(header[7:6]);
            tmpl_q <= header[5:4];
            pos_q  <= '0;
            acc_a  <= '0;
            acc_b  <= '0;
            held_v <= 1'b0;
        end else if (st_q == ST_IDLE) begin
            if (dout_ready && held_v) begin
                out_q  <= held_q;
                held_v <= 1'b0;
            end
        end else if ((st_q == ST_FETCH) && gen_ack) begin
            if (last) begin
                pos_q  <= '0;
                out_q  <= acc_a_n;
                held_q <= acc_b_n;
                held_v <= pair;
                acc_a  <= '0;
                acc_b  <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
                acc_a <= acc_a_n;
                acc_b <= acc_b_n;
            end
        end
    end

endmodule

// File: rtl/cbd_checker.sv
module cbd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       dout_ready,
    input logic       dout_valid,
    input logic [7:0] dout_data,
    input logic       gen_req,
    input logic [2:0] gen_order,
    input logic       gen_ack
);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid && !dout_ready && !start |=> dout_valid && $stable(dout_data)); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        gen_req && !gen_ack && !start |=> gen_req && $stable(gen_order)); // R10

    AST_SIDE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        gen_req |-> !dout_valid); // R10

    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !dout_valid && !gen_req); // R2

    AST_REQ_NEEDS_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_req) |-> $past(dout_ready)); // R10

endmodule

bind ctxplane_decoder cbd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .dout_ready(dout_ready),
    .dout_valid(dout_valid), .dout_data(dout_data), .gen_req(gen_req),
    .gen_order(gen_order), .gen_ack(gen_ack)
);

// File: tb/ctxplane_decoder_test.sv
`timescale 1ns/1ps
module ctxplane_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] header = '0;
    logic       dout_ready = 1'b0;
    logic       dout_valid;
    logic [7:0] dout_data;
    logic       gen_req;
    logic [2:0] gen_order;
    logic       gen_ack = 1'b0;
    logic       gen_bit = 1'b0;
    logic       gen_eor = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ctxplane_decoder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .header(header),
        .dout_ready(dout_ready), .dout_valid(dout_valid), .dout_data(dout_data),
        .gen_req(gen_req), .gen_order(gen_order), .gen_ack(gen_ack),
        .gen_bit(gen_bit), .gen_eor(gen_eor)
    );

    // vector: {header, eor style, byte count}
    localparam int NV = 9;
    localparam logic [17:0] VEC [NV] = '{
        {8'h00, 2'd0, 8'd16}, {8'h10, 2'd1, 8'd16}, {8'h60, 2'd0, 8'd40},
        {8'hB0, 2'd2, 8'd40}, {8'hC0, 2'd0, 8'd24}, {8'hF0, 2'd1, 8'd24},
        {8'h20, 2'd2, 8'd20}, {8'h70, 2'd1, 8'd40}, {8'h80, 2'd0, 8'd5}
    };

    // independent model state
    int         m_st  [32];
    bit         m_mps [32];
    bit [15:0]  m_hist[8];
    bit [2:0]   m_plane;
    bit [7:0]   m_cnt;
    bit [1:0]   m_mode, m_tmpl;
    int         m_pos;
    bit [7:0]   m_a, m_b;
    bit [7:0]   exp_mem [0:255];
    int         wr_i, rd_i, got, ack_cnt;
    bit [15:0]  lfsr;
    bit [1:0]   eor_style;

    function automatic bit [14:0] ref_evo(input int s);
        case (s)
            0: return {3'd0,6'd25,6'd25};  1: return {3'd0,6'd2,6'd1};
            2: return {3'd0,6'd3,6'd1};    3: return {3'd0,6'd4,6'd2};
            4: return {3'd0,6'd5,6'd3};    5: return {3'd1,6'd6,6'd4};
            6: return {3'd1,6'd7,6'd5};    7: return {3'd1,6'd8,6'd6};
            8: return {3'd1,6'd9,6'd7};    9: return {3'd2,6'd10,6'd8};
            10: return {3'd2,6'd11,6'd9};  11: return {3'd2,6'd12,6'd10};
            12: return {3'd2,6'd13,6'd11}; 13: return {3'd3,6'd14,6'd12};
            14: return {3'd3,6'd15,6'd13}; 15: return {3'd3,6'd16,6'd14};
            16: return {3'd3,6'd17,6'd15}; 17: return {3'd4,6'd18,6'd16};
            18: return {3'd4,6'd19,6'd17}; 19: return {3'd5,6'd20,6'd18};
            20: return {3'd5,6'd21,6'd19}; 21: return {3'd6,6'd22,6'd20};
            22: return {3'd6,6'd23,6'd21}; 23: return {3'd7,6'd24,6'd22};
            24: return {3'd7,6'd24,6'd23}; 25: return {3'd0,6'd26,6'd1};
            26: return {3'd1,6'd27,6'd2};  27: return {3'd2,6'd28,6'd4};
            28: return {3'd3,6'd29,6'd8};  29: return {3'd4,6'd30,6'd12};
            30: return {3'd5,6'd31,6'd16}; 31: return {3'd6,6'd32,6'd18};
            default: return {3'd7,6'd24,6'd22};
        endcase
    endfunction

    task automatic model_init(input bit [7:0] hdr);
        for (int i = 0; i < 32; i++) begin m_st[i] = 0; m_mps[i] = 0; end
        for (int i = 0; i < 8; i++) m_hist[i] = 0;
        m_mode = hdr[7:6]; m_tmpl = hdr[5:4];
        m_plane = (m_mode == 0) ? 3'd1 : (m_mode == 1) ? 3'd7 : (m_mode == 2) ? 3'd3 : 3'd0;
        m_cnt = 0; m_pos = 0; m_a = 0; m_b = 0; wr_i = 0; rd_i = 0;
    endtask

    // generator stub plus lockstep model
    always @(negedge clk) begin
        if (gen_req) begin
            bit [2:0] p; bit [15:0] h; bit [3:0] t; int c; bit [14:0] e; bit raw, eor, b;
            p = m_plane ^ 3'd1;
            if (m_mode == 1 && m_cnt[6:0] == 0) p = p + 3'd2;
            if (m_mode == 2 && m_cnt[6:0] == 0) p = p ^ 3'd2;
            if (m_mode == 3) p = m_cnt[2:0];
            h = m_hist[p];
            case (m_tmpl)
                0: t = {h[8], h[7], h[6], h[0]};
                1: t = {h[8], h[7], 1'b0, h[0]};
                2: t = {1'b0, h[7], h[6], h[0]};
                default: t = {h[8], h[7], h[1], h[0]};
            endcase
            c = {p[0], t};
            e = ref_evo(m_st[c]);
            checks++;
            if (gen_order !== e[14:12]) begin
                errors++;
                $display("FAIL R3 R4 R6 R7: gen_order actual %0d expected %0d (ctx %0d)", gen_order, e[14:12], c);
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            raw = lfsr[0];
            eor = (eor_style == 1) ? 1'b1 : (eor_style == 2) ? (lfsr[2] & lfsr[5] & lfsr[7]) : (lfsr[2] | lfsr[5]);
            b = raw ^ m_mps[c];
            if (eor) begin
                if (raw) begin
                    if (m_st[c] <= 1) m_mps[c] = ~m_mps[c];
                    m_st[c] = e[5:0];
                end else m_st[c] = e[11:6];
            end
            m_hist[p] = {h[14:0], b};
            m_plane = p; m_cnt = m_cnt + 8'd1;
            if (m_mode != 3) begin
                if (m_pos % 2 == 0) m_a[7 - m_pos/2] = b; else m_b[7 - m_pos/2] = b;
                if (m_pos == 15) begin
                    exp_mem[wr_i[7:0]] = m_a; exp_mem[wr_i[7:0] + 8'd1] = m_b;
                    wr_i += 2; m_pos = 0;
                end else m_pos++;
            end else begin
                m_a[m_pos] = b;
                if (m_pos == 7) begin exp_mem[wr_i[7:0]] = m_a; wr_i++; m_pos = 0; end
                else m_pos++;
            end
            gen_ack <= 1'b1; gen_bit <= raw; gen_eor <= eor; ack_cnt++;
        end else begin
            gen_ack <= 1'b0;
        end
    end

    // byte monitor
    always @(negedge clk) begin
        if (dout_valid && dout_ready) begin
            checks++;
            if (rd_i >= wr_i) begin
                errors++;
                $display("FAIL R8 R9: byte %0d actual %02h expected none", rd_i, dout_data);
            end else if (dout_data !== exp_mem[rd_i[7:0]]) begin
                errors++;
                $display("FAIL R1 R2 R5 R8 R9: byte %0d actual %02h expected %02h",
                         rd_i, dout_data, exp_mem[rd_i[7:0]]);
            end
            rd_i++; got++;
        end
    end

    task automatic do_start(input bit [7:0] hdr, input bit [15:0] seed, input bit [1:0] es);
        @(negedge clk);
        header = hdr; start = 1'b1; lfsr = seed; eor_style = es;
        model_init(hdr);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic get_byte();
        int tgt;
        tgt = got + 1;
        @(negedge clk);
        dout_ready = 1'b1;
        while (got < tgt) @(posedge clk);
        #1 dout_ready = 1'b0;
    endtask

    task automatic run_stream(input bit [7:0] hdr, input bit [15:0] seed, input bit [1:0] es, input int n);
        do_start(hdr, seed, es);
        for (int k = 0; k < n; k++) begin
            int a0;
            a0 = ack_cnt;
            get_byte();
            if (hdr[7:6] != 2'd3 && k % 2 == 1) begin
                checks++;
                if (ack_cnt != a0) begin
                    errors++;
                    $display("FAIL R8: held byte used %0d generator bits, expected 0", ack_cnt - a0);
                end
            end
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        got = 0; ack_cnt = 0; wr_i = 0; rd_i = 0; lfsr = 16'h1; eor_style = 0;
        repeat (3) @(negedge clk);
        checks++;  // R11
        if (dout_valid !== 1'b0 || gen_req !== 1'b0) begin
            errors++;
            $display("FAIL R11: valid/req actual %b%b expected 00", dout_valid, gen_req);
        end
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++)
            run_stream(VEC[v][17:10], 16'hACE1 + 16'(v) * 16'h1357, VEC[v][9:8], int'(VEC[v][7:0]));

        // R2: restart with the same header and seed, fresh result expected
        run_stream(8'h60, 16'hBEEF, 2'd1, 3);
        run_stream(8'h60, 16'hBEEF, 2'd1, 6);

        // R10: no output and no generator traffic without a consumer request
        do_start(8'h30, 16'h0F0F, 2'd0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            checks++;
            if (dout_valid !== 1'b0 || gen_req !== 1'b0) begin
                errors++;
                $display("FAIL R10: idle valid/req actual %b%b expected 00", dout_valid, gen_req);
            end
        end
        get_byte();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule